// File: doc/BRIEF.md
# UART control and status register file

This block is the register file through which a host configures a UART core and observes its condition. It is an APB slave with a 3-bit address and an 8-bit data path. It holds the line configuration (internal loopback, parity enable, odd or even parity), a general-purpose scratch byte and a 16-bit baud divisor that is written as two bytes. It exposes a read-only status byte that combines the live FIFO level flags with two sticky event bits.

The UART datapath feeds the block three level flags (transmit queue full, transmit queue empty, receive queue empty) and two single-cycle pulses, one for a receive error and one for a receive overflow. Each pulse sets a sticky bit that stays set until the host writes the control register. The configuration bits and the divisor leave the block as registered outputs. A divisor of zero is the reset value, and the core reads it as its built-in default rate. A new divisor is released to the core as a whole when its high byte is written, so the core never sees a mix of an old byte and a new byte.

Read data is registered in the APB setup cycle and is stable for the whole access cycle. The slave never inserts wait states and never reports an error.

Top module: `serial_cfg_regfile`

## Requirements
- R1: After synchronous reset, loopback, parity enable, parity odd, the divisor output, the scratch byte, the staged low divisor byte and both sticky bits are all 0.
- R2: A write to address 0 stores pwdata bits 0 (loopback), 1 (parity enable) and 2 (parity odd). These bits drive loop_en, par_en and par_odd from the cycle after the write. A read of address 0 returns them in the same positions, with bits 7:3 reading 0.
- R3: A read of address 1 returns tx_full in bit 0, tx_empty in bit 1 and rx_empty in bit 2, sampled in the setup cycle, and returns 0 in bits 7:5.
- R4: A one-cycle rx_err_pulse sets status bit 3 and a one-cycle rx_ovf_pulse sets status bit 4. Each bit stays set across later cycles and reads.
- R5: Any write to address 0 clears status bits 3 and 4, whatever data is written.
- R6: If an event pulse arrives in the same cycle as a write to address 0, the matching sticky bit ends up set.
- R7: Address 2 is an 8-bit scratch register that reads back the last value written to it.
- R8: A write to address 3 stages the low divisor byte, and a read of address 3 returns that staged byte. The baud_div output does not change until address 4 is written. Then baud_div becomes {written byte, staged low byte} in one step, and a read of address 4 returns baud_div[15:8].
- R9: Reads of addresses 5, 6 and 7 return 0. Writes to them change no register and no output.
- R10: pready is always 1 and pslverr is always 0.
- R11: Status is read-only: a write to address 1 changes neither the sticky bits nor any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 3 | APB register address |
| pwdata | input | 8 | APB write data |
| prdata | output | 8 | APB read data, registered in the setup cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tx_full | input | 1 | Live flag: transmit queue full |
| tx_empty | input | 1 | Live flag: transmit queue empty |
| rx_empty | input | 1 | Live flag: receive queue empty |
| rx_err_pulse | input | 1 | One-cycle pulse: receive framing or parity error |
| rx_ovf_pulse | input | 1 | One-cycle pulse: receive queue overflow |
| loop_en | output | 1 | Internal loopback enable |
| par_en | output | 1 | Parity enable |
| par_odd | output | 1 | Odd parity select (even when 0) |
| baud_div | output | 16 | Committed baud divisor, 0 selects the core default |

## Verification
The assertions assume a well-formed APB master. Every access starts with one setup cycle (psel high, penable low), is followed by exactly one access cycle, and keeps the address, direction and write data steady across both cycles. They also assume that the event inputs are single-cycle pulses in the clock domain of the block. The bench drives all accesses through one task that always produces this two-cycle shape, and it lowers psel between transfers. It raises each event pulse for exactly one clock. Event pulses are placed either well clear of control writes or exactly on the access cycle of a control write, so that the collision case in R6 is reached.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  // Register addresses; the core decodes the divisor as {hi, lo}.
  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_STAT  = 3'd1;
  localparam logic [2:0] ADR_SCR   = 3'd2;
  localparam logic [2:0] ADR_DIVLO = 3'd3;
  localparam logic [2:0] ADR_DIVHI = 3'd4;

  // Control field positions
  localparam int CF_LOOP = 0;
  localparam int CF_PAR  = 1;
  localparam int CF_ODD  = 2;

  // Status field positions
  localparam int SF_TXFULL  = 0;
  localparam int SF_TXEMPTY = 1;
  localparam int SF_RXEMPTY = 2;
  localparam int SF_ERR     = 3;
  localparam int SF_OVF     = 4;

  // Sticky event indices
  localparam int EV_ERR = 0;
  localparam int EV_OVF = 1;
  localparam int EV_NUM = 2;

  typedef struct packed {
    logic odd;
    logic par;
    logic loop;
  } line_cfg_t;

endpackage

// File: rtl/cfg_apb_decode.sv
module cfg_apb_decode #(
  parameter int ADDR_W = 3
) (
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  output logic [(1<<ADDR_W)-1:0]   wr_hit,
  output logic                     rd_setup
);
  localparam int NSLOT = 1 << ADDR_W;

  logic wr_access;
  assign wr_access = psel && penable && pwrite;
  assign rd_setup  = psel && !penable;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign wr_hit[i] = wr_access && (paddr == ADDR_W'(i));
  end
endmodule

// File: rtl/cfg_event_latch.sv
module cfg_event_latch #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev_pulse,
  input  logic           clr,
  output logic [NEV-1:0] ev_sticky
);
  for (genvar i = 0; i < NEV; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst)              ev_sticky[i] <= 1'b0;
      else if (ev_pulse[i]) ev_sticky[i] <= 1'b1;   // set beats clear
      else if (clr)         ev_sticky[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_divisor_stage.sv
module cfg_divisor_stage #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_lo,
  input  logic              wr_hi,
  output logic [DATA_W-1:0] lo_staged,
  output logic [DIV_W-1:0]  div_out
);
  localparam int HI_W = DIV_W - DATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_staged <= '0;
      div_out   <= '0;
    end else begin
      if (wr_lo) lo_staged <= wdata;
      if (wr_hi) div_out   <= {wdata[HI_W-1:0], lo_staged};
    end
  end
endmodule

// File: rtl/serial_cfg_regfile.sv
module serial_cfg_regfile
  import serial_cfg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_empty,
  input  logic              rx_err_pulse,
  input  logic              rx_ovf_pulse,
  output logic              loop_en,
  output logic              par_en,
  output logic              par_odd,
  output logic [DIV_W-1:0]  baud_div
);
  localparam int NSLOT = 1 << ADDR_W;
  localparam int HI_W  = DIV_W - DATA_W;

  logic [NSLOT-1:0]  wr_hit;
  logic              rd_setup;
  line_cfg_t         cfg_q;
  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] div_lo_stage;
  logic [EV_NUM-1:0] ev_in;
  logic [EV_NUM-1:0] evt_sticky;
  logic [DATA_W-1:0] rd_val;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  cfg_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .wr_hit   (wr_hit),
    .rd_setup (rd_setup)
  );

  assign ev_in[EV_ERR] = rx_err_pulse;
  assign ev_in[EV_OVF] = rx_ovf_pulse;

  cfg_event_latch #(.NEV(EV_NUM)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .ev_pulse  (ev_in),
    .clr       (wr_hit[ADR_CTRL]),
    .ev_sticky (evt_sticky)
  );

  cfg_divisor_stage #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .wdata     (pwdata),
    .wr_lo     (wr_hit[ADR_DIVLO]),
    .wr_hi     (wr_hit[ADR_DIVHI]),
    .lo_staged (div_lo_stage),
    .div_out   (baud_div)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      scratch_q <= '0;
    end else begin
      if (wr_hit[ADR_CTRL]) begin
        cfg_q.loop <= pwdata[CF_LOOP];
        cfg_q.par  <= pwdata[CF_PAR];
        cfg_q.odd  <= pwdata[CF_ODD];
      end
      if (wr_hit[ADR_SCR]) scratch_q <= pwdata;
    end
  end

  assign loop_en = cfg_q.loop;
  assign par_en  = cfg_q.par;
  assign par_odd = cfg_q.odd;

  always_comb begin
    rd_val = '0;
    case (paddr)
      ADR_CTRL: begin
        rd_val[CF_LOOP] = cfg_q.loop;
        rd_val[CF_PAR]  = cfg_q.par;
        rd_val[CF_ODD]  = cfg_q.odd;
      end
      ADR_STAT: begin
        rd_val[SF_TXFULL]  = tx_full;
        rd_val[SF_TXEMPTY] = tx_empty;
        rd_val[SF_RXEMPTY] = rx_empty;
        rd_val[SF_ERR]     = evt_sticky[EV_ERR];
        rd_val[SF_OVF]     = evt_sticky[EV_OVF];
      end
      ADR_SCR:   rd_val = scratch_q;
      ADR_DIVLO: rd_val = div_lo_stage;
      ADR_DIVHI: rd_val[HI_W-1:0] = baud_div[DIV_W-1:DATA_W];
      default:   rd_val = '0;
    endcase
  end

  // Read data captured in the setup cycle, stable through the access cycle
  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_val;
  end
endmodule

// File: rtl/serial_cfg_regfile_chk.sv
module serial_cfg_regfile_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              pready,
  input logic              pslverr,
  input logic              rx_err_pulse,
  input logic              rx_ovf_pulse,
  input logic              loop_en,
  input logic [DIV_W-1:0]  baud_div,
  input logic [1:0]        sticky
);
  logic ctrl_wr, hi_wr;
  assign ctrl_wr = psel && penable && pwrite && (paddr == ADDR_W'(0));
  assign hi_wr   = psel && penable && pwrite && (paddr == ADDR_W'(4));

  a_r10_handshake: assert property (@(posedge clk) disable iff (rst)
    pready && !pslverr);

  a_r2_loop_follows: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (loop_en == $past(pwdata[0])));

  a_r8_div_hold: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(baud_div));

  a_r4_err_sets: assert property (@(posedge clk) disable iff (rst)
    rx_err_pulse |=> sticky[0]);

  a_r4_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    rx_ovf_pulse |=> sticky[1]);

  a_r5_ctrl_clears: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !rx_err_pulse) |=> !sticky[0]);

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && rx_ovf_pulse) |=> sticky[1]);

  a_r11_sticky_no_fall: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> !$fell(sticky[0]));
endmodule

bind serial_cfg_regfile serial_cfg_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .psel         (psel),
  .penable      (penable),
  .pwrite       (pwrite),
  .paddr        (paddr),
  .pwdata       (pwdata),
  .pready       (pready),
  .pslverr      (pslverr),
  .rx_err_pulse (rx_err_pulse),
  .rx_ovf_pulse (rx_ovf_pulse),
  .loop_en      (loop_en),
  .baud_div     (baud_div),
  .sticky       (evt_sticky)
);

// File: tb/tb_serial_cfg_regfile.sv
`timescale 1ns/1ps
module tb_serial_cfg_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [2:0]  paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic        pready, pslverr;
  logic        tx_full = 1'b0, tx_empty = 1'b1, rx_empty = 1'b1;
  logic        rx_err_pulse = 1'b0, rx_ovf_pulse = 1'b0;
  logic        loop_en, par_en, par_odd;
  logic [15:0] baud_div;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  serial_cfg_regfile dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_empty(rx_empty), .rx_err_pulse(rx_err_pulse),
    .rx_ovf_pulse(rx_ovf_pulse), .loop_en(loop_en), .par_en(par_en),
    .par_odd(par_odd), .baud_div(baud_div)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each completed read against the scoreboard
  always @(negedge clk) begin
    if (!rst && psel) begin
      if (!pready || pslverr) check("R10 handshake", {pready, pslverr}, 2'b10);
    end
    if (!rst && psel && penable && !pwrite) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), prdata, exp_q.pop_front());
    end
  end

  task automatic apb_write(input logic [2:0] a, input logic [7:0] d, input bit err_hit = 0);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    if (err_hit) begin rx_err_pulse = 1; rx_ovf_pulse = 1; end
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
    rx_err_pulse = 0; rx_ovf_pulse = 0;
  endtask

  task automatic apb_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  task automatic pulse(input bit err, input bit ovf);
    @(posedge clk); #1;
    rx_err_pulse = err; rx_ovf_pulse = ovf;
    @(posedge clk); #1;
    rx_err_pulse = 0; rx_ovf_pulse = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check("R1 cfg outputs", {loop_en, par_en, par_odd}, 3'b000);
    check("R1 baud_div", baud_div, 16'h0000);
    apb_read(3'd0, 8'h00, "R1 ctrl");
    apb_read(3'd2, 8'h00, "R1 scratch");
    apb_read(3'd3, 8'h00, "R1 div lo");
    apb_read(3'd4, 8'h00, "R1 div hi");
    apb_read(3'd1, 8'h06, "R1 R3 status at reset");

    // R2 control
    apb_write(3'd0, 8'hFF);
    check("R2 cfg all set", {loop_en, par_en, par_odd}, 3'b111);
    apb_read(3'd0, 8'h07, "R2 ctrl readback");
    apb_write(3'd0, 8'h05);
    check("R2 cfg 101", {par_odd, par_en, loop_en}, 3'b101);
    apb_read(3'd0, 8'h05, "R2 ctrl readback 2");

    // R7 scratch
    apb_write(3'd2, 8'hA5);
    apb_read(3'd2, 8'hA5, "R7 scratch A5");
    apb_write(3'd2, 8'h3C);
    apb_read(3'd2, 8'h3C, "R7 scratch 3C");

    // R3 live flags
    tx_full = 1; tx_empty = 0; rx_empty = 0;
    apb_read(3'd1, 8'h01, "R3 full only");
    tx_full = 0; tx_empty = 1; rx_empty = 0;
    apb_read(3'd1, 8'h02, "R3 tx empty only");
    tx_empty = 0; rx_empty = 1;
    apb_read(3'd1, 8'h04, "R3 rx empty only");
    rx_empty = 0;

    // R4 sticky set and hold
    pulse(1, 0);
    repeat (3) @(posedge clk);
    apb_read(3'd1, 8'h08, "R4 err sticky");
    apb_read(3'd1, 8'h08, "R4 err holds");
    pulse(0, 1);
    apb_read(3'd1, 8'h18, "R4 ovf sticky");

    // R11 status write ignored
    apb_write(3'd1, 8'h00);
    apb_read(3'd1, 8'h18, "R11 status write ignored");

    // R5 ctrl write clears
    apb_write(3'd0, 8'h02);
    apb_read(3'd1, 8'h00, "R5 sticky cleared");
    check("R5 cfg after clear write", {par_odd, par_en, loop_en}, 3'b010);

    // R6 set wins over clear
    apb_write(3'd0, 8'h00, 1);
    apb_read(3'd1, 8'h18, "R6 set wins");
    apb_write(3'd0, 8'h00);
    apb_read(3'd1, 8'h00, "R6 later clear");

    // R8 divisor staging
    apb_write(3'd3, 8'h34);
    check("R8 div held after lo", baud_div, 16'h0000);
    apb_read(3'd3, 8'h34, "R8 staged lo");
    apb_read(3'd4, 8'h00, "R8 hi still 0");
    apb_write(3'd4, 8'h12);
    check("R8 div commit", baud_div, 16'h1234);
    apb_read(3'd4, 8'h12, "R8 hi readback");
    apb_write(3'd3, 8'hB2);
    check("R8 div held after second lo", baud_div, 16'h1234);
    apb_write(3'd4, 8'h01);
    check("R8 div commit 2", baud_div, 16'h01B2);

    // R9 unmapped
    apb_write(3'd0, 8'h03);
    apb_write(3'd5, 8'hFF);
    apb_write(3'd6, 8'hFF);
    apb_write(3'd7, 8'hFF);
    apb_read(3'd5, 8'h00, "R9 read 5");
    apb_read(3'd6, 8'h00, "R9 read 6");
    apb_read(3'd7, 8'h00, "R9 read 7");
    check("R9 cfg unchanged", {par_odd, par_en, loop_en}, 3'b011);
    check("R9 div unchanged", baud_div, 16'h01B2);
    apb_read(3'd2, 8'h3C, "R9 scratch unchanged");
    apb_read(3'd0, 8'h03, "R9 ctrl unchanged");

    repeat (3) @(posedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule